// File: doc/BRIEF.md
# Thread-Block Resource Admission Allocator

For one compute core, this block decides whether one more thread block of a kernel fits next to the blocks already resident, and if so it reserves the resources. A request carries the block's thread count, its registers per thread and its shared-memory bytes, together with a command: check only, occupy or release. The block keeps four occupancy counters (threads, shared memory, registers, resident blocks), a bitmap of hardware thread slots and a table that records the starting thread slot for each hardware block ID.

The thread count is first padded to a whole number of warps. The capacity limits are then tested. After that a sequential first-fit search runs over aligned windows of the padded size, one candidate per cycle. The controller has six named states. IDLE accepts a request (IDLE→EVAL). EVAL runs the capacity, duplicate-ID and underflow tests and goes to SCAN (check or occupy that passes), FREE (release that passes) or FINISH (any failure). SCAN steps to the next candidate and stays in SCAN on a busy window. It goes to COMMIT on a free window for occupy, and to FINISH on a free window for check or when the window runs past the core. COMMIT and FREE update the state and go to FINISH. FINISH raises `done` for one cycle and returns to IDLE.

Top module: `tba_admit`

## Requirements
- R1: The thread count is rounded up to the next multiple of WARP (default 8) before any capacity test, charge or slot search. The padded size is S.
- R2: The register charge is S × (registers per thread rounded up to a multiple of 4).
- R3: A request is refused (grant=0) when threads in use + S exceeds THREADS (default 64).
- R4: A request is refused when shared memory in use + requested bytes exceeds SMEM (default 4096). Equality is admitted.
- R5: A request is refused when registers in use + register charge exceeds REG_FILE (default 1024). Equality is admitted.
- R6: A request is refused when resident blocks + 1 exceeds MAX_BLOCKS (default 4).
- R7: Slot search tests the start positions 0, S, 2S, … in order and picks the first one whose S slots are all free. If none fits inside THREADS the request is refused. A granted request reports the chosen start on `start_slot`.
- R8: req_op=0 (check, as is the unused code 3) runs every test, including the search, and changes no counter, bitmap bit or table entry.
- R9: req_op=1 (occupy) on a grant adds the charges, marks the S slots and records the start against req_id. req_op=2 (release) reads that start, reports it on `start_slot`, frees the S slots, erases the entry and subtracts the same charges computed from the request fields.
- R10: Asserting rst_n low empties every counter, the bitmap and the table, and clears busy, done, grant and err.
- R11: Occupying an ID that is already mapped, or releasing an unmapped ID or an amount larger than any counter holds, is refused with no state change and sets `err`, which stays high until reset.
- R12: `busy` is high from the cycle after acceptance until `done`. `done` is a one-cycle pulse. Latency is one evaluation cycle, plus one cycle per tested candidate, plus one more for occupy. Requests arriving while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken in IDLE |
| req_op | input | 2 | 0 check, 1 occupy, 2 release |
| req_id | input | 2 | Hardware block ID |
| req_threads | input | 7 | Threads in the block |
| req_regs | input | 8 | Registers per thread |
| req_smem | input | 13 | Shared-memory bytes |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result valid pulse |
| grant | output | 1 | Request admitted or released |
| start_slot | output | 6 | Chosen or released start slot |
| err | output | 1 | Sticky misuse flag |

## Verification
The bench sets up fragmented slot maps. In these maps enough threads are free in total but no aligned window exists, so a search that ignored alignment or stopped early would grant wrongly or return the wrong start. It probes each capacity limit at equality and one past it. It also picks thread and register counts where dropping the warp padding or the register rounding would flip the outcome. It checks that check-only requests leave later placements unchanged, that released slots are reused first, and that duplicate IDs and oversized releases set a sticky error without disturbing occupancy. The busy cycles are counted so that a scan that skips candidates or adds stages shows up.

// File: rtl/tba_pkg.sv
package tba_pkg;
    localparam logic [1:0] OP_CHECK   = 2'd0;
    localparam logic [1:0] OP_OCCUPY  = 2'd1;
    localparam logic [1:0] OP_RELEASE = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EVAL,
        S_SCAN,
        S_COMMIT,
        S_FREE,
        S_FINISH
    } st_e;
endpackage

// File: rtl/tba_cost.sv
module tba_cost #(
    parameter int WARP  = 8,
    parameter int THR_W = 7,
    parameter int REG_W = 8
) (
    input  logic [THR_W-1:0] threads,
    input  logic [REG_W-1:0] regs,
    output logic [31:0]      pad,
    output logic [31:0]      cost
);
    localparam int WLG = $clog2(WARP);

    logic [31:0] thr_up;
    logic [31:0] rnd;

    always_comb begin
        thr_up = 32'(threads) + 32'(WARP - 1);
        pad    = (thr_up >> WLG) << WLG;
        rnd    = (32'(regs) + 32'd3) & ~32'd3;
        cost   = pad * rnd;
    end
endmodule

// File: rtl/tba_window.sv
module tba_window #(
    parameter int T = 64
) (
    input  logic [T-1:0] bitmap,
    input  logic [31:0]  base,
    input  logic [31:0]  size,
    output logic [T-1:0] mask,
    output logic         fits,
    output logic         clear
);
    logic [31:0] lim;
    assign lim = base + size;

    for (genvar i = 0; i < T; i++) begin : g_bit
        assign mask[i] = (32'(i) >= base) && (32'(i) < lim);
    end

    assign fits  = lim <= 32'(T);
    assign clear = ~|(mask & bitmap);
endmodule

// File: rtl/tba_map.sv
module tba_map #(
    parameter int N   = 4,
    parameter int IDW = 2,
    parameter int SW  = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           clr_en,
    input  logic [IDW-1:0] id,
    input  logic [SW-1:0]  wr_start,
    output logic           rd_valid,
    output logic [SW-1:0]  rd_start
);
    logic          vld [N];
    logic [SW-1:0] st  [N];

    for (genvar e = 0; e < N; e++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld[e] <= 1'b0;
                st[e]  <= '0;
            end else if (wr_en && id == IDW'(e)) begin
                vld[e] <= 1'b1;
                st[e]  <= wr_start;
            end else if (clr_en && id == IDW'(e)) begin
                vld[e] <= 1'b0;
            end
        end
    end

    assign rd_valid = vld[id];
    assign rd_start = st[id];
endmodule

// File: rtl/tba_admit.sv
module tba_admit
    import tba_pkg::*;
#(
    parameter int THREADS    = 64,
    parameter int WARP       = 8,
    parameter int REG_FILE   = 1024,
    parameter int SMEM       = 4096,
    parameter int MAX_BLOCKS = 4,
    parameter int REG_W      = 8,
    localparam int TW  = $clog2(THREADS + 1),
    localparam int SW  = $clog2(THREADS),
    localparam int SMW = $clog2(SMEM + 1),
    localparam int RFW = $clog2(REG_FILE + 1),
    localparam int BW  = $clog2(MAX_BLOCKS + 1),
    localparam int IDW = $clog2(MAX_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [IDW-1:0]   req_id,
    input  logic [TW-1:0]    req_threads,
    input  logic [REG_W-1:0] req_regs,
    input  logic [SMW-1:0]   req_smem,
    output logic             busy,
    output logic             done,
    output logic             grant,
    output logic [SW-1:0]    start_slot,
    output logic             err
);
    st_e state, nxt;

    logic [1:0]       r_op;
    logic [IDW-1:0]   r_id;
    logic [TW-1:0]    r_thr;
    logic [REG_W-1:0] r_regs;
    logic [SMW-1:0]   r_smem;
    logic [31:0]      cand;

    logic [TW-1:0]    thr_used;
    logic [SMW-1:0]   smem_used;
    logic [RFW-1:0]   reg_used;
    logic [BW-1:0]    blk_used;
    logic [THREADS-1:0] bitmap;

    logic [31:0]      pad, cost;
    logic [THREADS-1:0] win_mask;
    logic             win_fits, win_clear;
    logic             map_valid;
    logic [SW-1:0]    map_start;
    logic [31:0]      win_base;
    logic             is_occ, is_rel, cap_fail, rel_bad;

    tba_cost #(.WARP(WARP), .THR_W(TW), .REG_W(REG_W)) u_cost (
        .threads(r_thr), .regs(r_regs), .pad(pad), .cost(cost)
    );

    assign is_occ   = (r_op == OP_OCCUPY);
    assign is_rel   = (r_op == OP_RELEASE);
    assign win_base = is_rel ? 32'(map_start) : cand;

    tba_window #(.T(THREADS)) u_win (
        .bitmap(bitmap), .base(win_base), .size(pad),
        .mask(win_mask), .fits(win_fits), .clear(win_clear)
    );

    tba_map #(.N(MAX_BLOCKS), .IDW(IDW), .SW(SW)) u_map (
        .clk(clk), .rst_n(rst_n),
        .wr_en(state == S_COMMIT), .clr_en(state == S_FREE),
        .id(r_id), .wr_start(start_slot),
        .rd_valid(map_valid), .rd_start(map_start)
    );

    assign cap_fail = (32'(thr_used) + pad > 32'(THREADS))
                   || (32'(smem_used) + 32'(r_smem) > 32'(SMEM))
                   || (32'(reg_used) + cost > 32'(REG_FILE))
                   || (32'(blk_used) + 32'd1 > 32'(MAX_BLOCKS));

    assign rel_bad  = !map_valid
                   || (32'(thr_used) < pad)
                   || (smem_used < r_smem)
                   || (32'(reg_used) < cost)
                   || (blk_used == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (req_valid) nxt = S_EVAL;
            S_EVAL: begin
                if (is_rel)                    nxt = rel_bad ? S_FINISH : S_FREE;
                else if (is_occ && map_valid)  nxt = S_FINISH;
                else if (cap_fail)             nxt = S_FINISH;
                else                           nxt = S_SCAN;
            end
            S_SCAN: begin
                if (!win_fits)      nxt = S_FINISH;
                else if (win_clear) nxt = is_occ ? S_COMMIT : S_FINISH;
            end
            S_COMMIT: nxt = S_FINISH;
            S_FREE:   nxt = S_FINISH;
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_op <= '0; r_id <= '0; r_thr <= '0; r_regs <= '0; r_smem <= '0;
            cand <= '0;
            thr_used <= '0; smem_used <= '0; reg_used <= '0; blk_used <= '0;
            bitmap <= '0;
            grant <= 1'b0; start_slot <= '0; err <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    r_op <= req_op; r_id <= req_id; r_thr <= req_threads;
                    r_regs <= req_regs; r_smem <= req_smem;
                    cand <= '0;
                end
                S_EVAL: begin
                    grant <= 1'b0;
                    if (is_rel) begin
                        if (rel_bad) err <= 1'b1;
                        else         start_slot <= map_start;
                    end else if (is_occ && map_valid) begin
                        err <= 1'b1;
                    end
                end
                S_SCAN: begin
                    if (win_fits && win_clear) begin
                        start_slot <= SW'(cand);
                        if (!is_occ) grant <= 1'b1;
                    end else if (win_fits) begin
                        cand <= cand + pad;
                    end
                end
                S_COMMIT: begin
                    thr_used  <= thr_used + TW'(pad);
                    smem_used <= smem_used + r_smem;
                    reg_used  <= reg_used + RFW'(cost);
                    blk_used  <= blk_used + BW'(1);
                    bitmap    <= bitmap | win_mask;
                    grant     <= 1'b1;
                end
                S_FREE: begin
                    thr_used  <= thr_used - TW'(pad);
                    smem_used <= smem_used - r_smem;
                    reg_used  <= reg_used - RFW'(cost);
                    blk_used  <= blk_used - BW'(1);
                    bitmap    <= bitmap & ~win_mask;
                    grant     <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy = (state != S_IDLE);
    assign done = (state == S_FINISH);

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r12_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    a_r3_thread_cap: assert property (@(posedge clk) disable iff (!rst_n)
        32'(thr_used) <= 32'(THREADS));
    a_r4_smem_cap: assert property (@(posedge clk) disable iff (!rst_n)
        32'(smem_used) <= 32'(SMEM));
    a_r5_reg_cap: assert property (@(posedge clk) disable iff (!rst_n)
        32'(reg_used) <= 32'(REG_FILE));
    a_r6_block_cap: assert property (@(posedge clk) disable iff (!rst_n)
        32'(blk_used) <= 32'(MAX_BLOCKS));
    a_r8_check_keeps_map: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SCAN && r_op != OP_OCCUPY) |=> $stable(bitmap));
    a_r9_commit_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COMMIT) |=> ((bitmap & $past(win_mask)) == $past(win_mask)));
    a_r9_free_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FREE) |=> ((bitmap & $past(win_mask)) == '0));
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: tb/sim_tba_admit.sv
module sim_tba_admit;
    localparam int CLK_NS = 10;
    localparam logic [1:0] CHK = 2'd0, OCC = 2'd1, REL = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [1:0] req_id = '0;
    logic [6:0] req_threads = '0;
    logic [7:0] req_regs = '0;
    logic [12:0] req_smem = '0;
    logic busy, done, grant, err;
    logic [5:0] start_slot;

    int nchk = 0, nfail = 0;
    int lat, r_grant, r_start, r_err, post_done, post_busy;

    always #(CLK_NS/2) clk = ~clk;

    tba_admit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_id(req_id), .req_threads(req_threads), .req_regs(req_regs),
        .req_smem(req_smem), .busy(busy), .done(done), .grant(grant),
        .start_slot(start_slot), .err(err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic req(input logic [1:0] op, input int id, input int thr,
                       input int regs, input int smem);
        int guard = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_id = 2'(id);
        req_threads = 7'(thr); req_regs = 8'(regs); req_smem = 13'(smem);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!done && guard < 1000) begin
            lat++; guard++;
            @(negedge clk);
        end
        if (guard >= 1000) begin
            nchk++; nfail++;
            $display("FAIL R12: request hung, got busy expected done");
        end
        r_grant = int'(grant); r_start = int'(start_slot); r_err = int'(err);
        @(negedge clk);
        post_done = int'(done); post_busy = int'(busy);
    endtask

    task automatic t_reset_state();   // R10
        do_reset();
        chk("R10 busy after reset", int'(busy), 0);
        chk("R10 done after reset", int'(done), 0);
        chk("R10 grant after reset", int'(grant), 0);
        chk("R10 err after reset", int'(err), 0);
        req(CHK, 0, 64, 0, 0);
        chk("R10 empty core admits full block", r_grant, 1);
        chk("R10 empty core start", r_start, 0);
    endtask

    task automatic t_padding_first_fit();   // R1 R7 R12 R3
        do_reset();
        req(OCC, 0, 5, 4, 0);
        chk("R1 occupy 5 threads grant", r_grant, 1);
        chk("R7 first block at 0", r_start, 0);
        chk("R12 latency one candidate occupy", lat, 3);
        chk("R12 done pulse single", post_done, 0);
        chk("R12 idle after done", post_busy, 0);
        req(OCC, 1, 9, 0, 0);
        chk("R1 9 threads padded to 16 start", r_start, 16);
        chk("R12 latency two candidates occupy", lat, 4);
        req(OCC, 2, 8, 0, 0);
        chk("R7 fills hole at 8", r_start, 8);
        req(CHK, 0, 32, 0, 0);
        chk("R7 check 32 grant", r_grant, 1);
        chk("R7 check 32 start", r_start, 32);
        chk("R12 latency two candidates check", lat, 3);
        req(CHK, 0, 33, 0, 0);
        chk("R3 R1 padded 40 exceeds threads", r_grant, 0);
    endtask

    task automatic t_fragment();   // R7
        do_reset();
        req(OCC, 0, 8, 0, 0);
        req(OCC, 1, 24, 0, 0);
        chk("R7 24-wide block at 24", r_start, 24);
        req(CHK, 0, 32, 0, 0);
        chk("R7 no aligned 32 window", r_grant, 0);
        req(CHK, 0, 16, 0, 0);
        chk("R7 16 window grant", r_grant, 1);
        chk("R7 16 window at 48", r_start, 48);
    endtask

    task automatic t_registers();   // R2 R5
        do_reset();
        req(CHK, 0, 32, 32, 0);
        chk("R5 exactly full register file", r_grant, 1);
        req(CHK, 0, 32, 33, 0);
        chk("R5 register file exceeded", r_grant, 0);
        req(OCC, 0, 8, 1, 0);
        chk("R2 small charge grant", r_grant, 1);
        req(CHK, 0, 25, 30, 0);
        chk("R2 padded thread charge refused", r_grant, 0);
        req(CHK, 0, 32, 29, 0);
        chk("R2 rounded register charge refused", r_grant, 0);
        req(CHK, 0, 32, 28, 0);
        chk("R5 under limit grant", r_grant, 1);
    endtask

    task automatic t_smem();   // R4
        do_reset();
        req(CHK, 0, 8, 0, 4096);
        chk("R4 exactly full smem", r_grant, 1);
        req(CHK, 0, 8, 0, 4097);
        chk("R4 smem exceeded", r_grant, 0);
        req(OCC, 0, 8, 0, 4000);
        req(CHK, 0, 8, 0, 96);
        chk("R4 remaining smem fits", r_grant, 1);
        req(CHK, 0, 8, 0, 97);
        chk("R4 remaining smem exceeded", r_grant, 0);
    endtask

    task automatic t_blocks();   // R6
        do_reset();
        for (int i = 0; i < 4; i++) begin
            req(OCC, i, 8, 0, 0);
            chk("R6 block occupy start", r_start, 8 * i);
        end
        req(CHK, 0, 8, 0, 0);
        chk("R6 block limit refuses", r_grant, 0);
        chk("R6 no error on limit", r_err, 0);
    endtask

    task automatic t_check_only();   // R8
        do_reset();
        req(CHK, 0, 64, 0, 0);
        chk("R8 first check grant", r_grant, 1);
        req(CHK, 1, 64, 0, 0);
        chk("R8 second check grant", r_grant, 1);
        req(OCC, 0, 64, 0, 0);
        chk("R8 occupy after checks grant", r_grant, 1);
        chk("R8 occupy after checks start", r_start, 0);
    endtask

    task automatic t_release();   // R9 R11
        do_reset();
        req(OCC, 0, 16, 2, 100);
        req(OCC, 1, 16, 2, 100);
        req(REL, 0, 16, 2, 100);
        chk("R9 release grant", r_grant, 1);
        chk("R9 release reports start", r_start, 0);
        req(OCC, 2, 8, 0, 0);
        chk("R9 freed slots reused", r_start, 0);
        req(REL, 0, 16, 2, 100);
        chk("R11 unmapped release refused", r_grant, 0);
        chk("R11 unmapped release err", r_err, 1);
        req(CHK, 0, 8, 0, 0);
        chk("R11 err stays after good request", r_err, 1);
        chk("R11 later check still granted", r_grant, 1);
        do_reset();
        chk("R10 reset clears err", int'(err), 0);
        req(OCC, 1, 8, 0, 0);
        chk("R10 old mapping gone", r_err, 0);
    endtask

    task automatic t_misuse();   // R11
        do_reset();
        req(OCC, 0, 8, 0, 0);
        req(REL, 0, 16, 0, 0);
        chk("R11 oversized release refused", r_grant, 0);
        chk("R11 oversized release err", r_err, 1);
        req(CHK, 0, 64, 0, 0);
        chk("R11 occupancy unchanged", r_grant, 0);
        req(REL, 0, 8, 0, 0);
        chk("R11 correct release still works", r_grant, 1);
        req(CHK, 0, 64, 0, 0);
        chk("R9 core empty after release", r_grant, 1);
        do_reset();
        req(OCC, 0, 8, 0, 0);
        req(OCC, 0, 8, 0, 0);
        chk("R11 duplicate id refused", r_grant, 0);
        chk("R11 duplicate id err", r_err, 1);
        req(CHK, 0, 8, 0, 0);
        chk("R11 duplicate took no slots", r_start, 8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_padding_first_fit();
        t_fragment();
        t_registers();
        t_smem();
        t_blocks();
        t_check_only();
        t_release();
        t_misuse();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule